// File: doc/BRIEF.md
# Open-Drain Port with Shared Bias Pins

This block is a small processor-visible I/O port whose pins can only be pulled low or released. Each bit of a data register controls one pull-down transistor. A zero turns the transistor on and pulls the pin low. A one turns it off and lets the pin float. A per-bit direction register chooses between two behaviours. An output bit reads back its latched value. An input bit keeps its transistor off and reads back the pad level, which passes through a two-flop synchronizer first.

Two of the pins, bits 2 and 3, are shared with the bias-voltage inputs of an LCD driver. A function-select bit, taken from the LCD control register, decides whether these pins act as bias inputs or as ordinary port pins. In bias mode their pull-downs are held off and their read value is forced to zero.

A stop-mode input and a standby pin-state bit work together. When the standby bit is set at the moment stop mode is entered, every pull-down is released. Otherwise the pins keep the drive their data bits give them.

Top module: `opd_port`

## Requirements
- R1: After reset every data bit is 1, every direction bit is 0 (input), and no pull-down is enabled.
- R2: A pin whose direction bit is 1 enables its pull-down (`pd_en` = 1) exactly when its data bit is 0, unless R5 or R7 overrides this.
- R3: While `rd_en` is 1, an output pin (direction bit 1) returns its data-register bit on `rd_data`, in the same cycle, whatever the pad level.
- R4: An input pin (direction bit 0) never enables its pull-down. It returns the pad level on `rd_data`, and a pad change becomes visible after the second rising clock edge following it.
- R5: While `lcd_port_sel` is 0, pins 2 and 3 are bias inputs. Their `pd_en` is 0 and their read bits are 0, even if the data bit is 0 and the direction bit is 1.
- R6: While `lcd_port_sel` is 1, pins 2 and 3 behave like pins 0 and 1.
- R7: If `stby_hiz` is 1 in the cycle where `stop_req` rises, then all `pd_en` bits are 0 for as long as `stop_req` stays 1. When stop mode ends, the drive set by the registers returns.
- R8: If `stby_hiz` is 0 when stop mode is entered, then the pins keep their register-defined drive. A change of `stby_hiz` during stop mode has no effect until the next entry.
- R9: While `rd_en` is 0, `rd_data` is all zeros.
- R10: A write with `wr_en` = 1 loads `wr_data` into the direction register when `wr_dir` is 1, and into the data register when `wr_dir` is 0. The new value takes effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_dir | input | 1 | Write target: 1 selects the direction register, 0 selects the data register |
| wr_data | input | 4 | Write value |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 4 | Combined port read value |
| pad_in | input | 4 | Pad input levels (asynchronous) |
| pd_en | output | 4 | Pull-down transistor enables, 1 = pull low |
| lcd_port_sel | input | 1 | 0 = pins 2 and 3 act as bias inputs, 1 = they act as port pins |
| stop_req | input | 1 | Stop mode active |
| stby_hiz | input | 1 | Standby pin-state bit, 1 = release all pins in stop mode |

## Verification
The bench builds the block with its default parameters: a 4-bit port, a shared pair at bits 2 and 3, and two synchronizer stages. With a narrow port, one vector can place every pin in a different role at once: output driving low, output released, input, and bias pin. With only two synchronizer stages, the exact edge at which a pad change first becomes visible is easy to reach and can be checked directly. The table of vectors covers combinations of direction, data, pad level, function select and stop entry. Directed tests cover the reset state, how `stby_hiz` is captured at stop entry, and the zero read value when no read is in progress.

// File: rtl/opd_pkg.sv
package opd_pkg;

  // Bit mask with n ones starting at bit lo.
  function automatic logic [31:0] span_mask(int lo, int n);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) begin
      m[i] = (i >= lo) && (i < lo + n);
    end
    return m;
  endfunction

  // Value one pin contributes to a port read.
  function automatic logic read_bit(logic bias, logic dir, logic latch, logic pad);
    if (bias) return 1'b0;
    return dir ? latch : pad;
  endfunction

  // Pull-down enable for one pin.
  function automatic logic pull_bit(logic bias, logic dir, logic latch, logic force_off);
    return !bias && !force_off && dir && !latch;
  endfunction

endpackage

// File: rtl/opd_sync.sv
module opd_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign sync_out = stg[STAGES-1];

  // R4: the output follows the input of two edges earlier (default depth)
  a_r4_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (STAGES == 2 && $past(rst_n, 2)) |-> (sync_out == $past(async_in, 2)));
endmodule

// File: rtl/opd_regs.sv
module opd_regs #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_dir,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q
);
  wire data_wr_evt = wr_en && !wr_dir;
  wire dir_wr_evt  = wr_en &&  wr_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '1;
      dir_q  <= '0;
    end else begin
      if (data_wr_evt) data_q <= wr_data;
      if (dir_wr_evt)  dir_q  <= wr_data;
    end
  end

  // R10: a data write lands next edge and leaves the direction register alone
  a_r10_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_evt |=> (data_q == $past(wr_data)) && $stable(dir_q));
  a_r10_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr_evt |=> (dir_q == $past(wr_data)) && $stable(data_q));
  a_r10_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(data_q) && $stable(dir_q));
endmodule

// File: rtl/opd_stop_ctrl.sv
module opd_stop_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic stby_hiz,
  output logic force_off
);
  logic stop_q;
  logic hiz_lat;
  wire  stop_entry = stop_req && !stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q  <= 1'b0;
      hiz_lat <= 1'b0;
    end else begin
      stop_q <= stop_req;
      if (stop_entry) hiz_lat <= stby_hiz;
    end
  end

  // At the entry cycle the live bit decides, afterwards the captured one.
  assign force_off = stop_req && (stop_entry ? stby_hiz : hiz_lat);

  // R8: the captured standby bit cannot change while stop mode persists
  a_r8_hiz_held: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && stop_q) |=> (stop_req |-> $stable(hiz_lat)));
  // R7: release is never forced outside stop mode
  a_r7_only_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_req |-> !force_off);
endmodule

// File: rtl/opd_pin_ctrl.sv
module opd_pin_ctrl
  import opd_pkg::*;
#(
  parameter int               WIDTH       = 4,
  parameter logic [WIDTH-1:0] SHARED_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] pad_sync,
  input  logic             lcd_port_sel,
  input  logic             force_off,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] pd_en
);
  logic [WIDTH-1:0] bias_act;
  logic [WIDTH-1:0] rd_bits;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign bias_act[i] = SHARED_MASK[i] && !lcd_port_sel;
    assign rd_bits[i]  = read_bit(bias_act[i], dir_q[i], data_q[i], pad_sync[i]);
    assign pd_en[i]    = pull_bit(bias_act[i], dir_q[i], data_q[i], force_off);
  end

  assign rd_data = rd_en ? rd_bits : '0;

  // R4: an input pin never pulls
  a_r4_input_released: assert property (@(posedge clk) disable iff (!rst_n)
    ((pd_en & ~dir_q) == '0));
  // R2: a pull happens only on a latched zero
  a_r2_pull_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((pd_en & data_q) == '0));
  // R9: idle read bus is quiet
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));
endmodule

// File: rtl/opd_port.sv
module opd_port
  import opd_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SHARED_LO   = 2,
  parameter int SHARED_N    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_dir,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pd_en,
  input  logic             lcd_port_sel,
  input  logic             stop_req,
  input  logic             stby_hiz
);
  localparam logic [31:0]      MASK_FULL   = span_mask(SHARED_LO, SHARED_N);
  localparam logic [WIDTH-1:0] SHARED_MASK = MASK_FULL[WIDTH-1:0];

  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pad_sync;
  logic             force_off;

  opd_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dir(wr_dir),
    .wr_data(wr_data), .data_q(data_q), .dir_q(dir_q)
  );

  opd_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pad_sync)
  );

  opd_stop_ctrl u_stop (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stby_hiz(stby_hiz),
    .force_off(force_off)
  );

  opd_pin_ctrl #(.WIDTH(WIDTH), .SHARED_MASK(SHARED_MASK)) u_pins (
    .clk(clk), .rst_n(rst_n), .data_q(data_q), .dir_q(dir_q),
    .pad_sync(pad_sync), .lcd_port_sel(lcd_port_sel), .force_off(force_off),
    .rd_en(rd_en), .rd_data(rd_data), .pd_en(pd_en)
  );

  // R5: bias pins neither pull nor read as one
  a_r5_bias_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_port_sel |-> (((pd_en | rd_data) & SHARED_MASK) == '0));
  // R7: stop entered with the standby bit set keeps every pin released
  a_r7_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stop_req) && stby_hiz) |=> (stop_req |-> (pd_en == '0)));
endmodule

// File: tb/opd_port_bench.sv
module opd_port_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, wr_dir = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0, pad_in = '0;
  logic         lcd_port_sel = 1'b0, stop_req = 1'b0, stby_hiz = 1'b0;
  logic [W-1:0] rd_data, pd_en;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  opd_port u_opd_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dir(wr_dir),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .pad_in(pad_in),
    .pd_en(pd_en), .lcd_port_sel(lcd_port_sel), .stop_req(stop_req),
    .stby_hiz(stby_hiz)
  );

  typedef struct packed {
    logic [3:0] dir;
    logic [3:0] dat;
    logic [3:0] pad;
    logic       sel;
    logic       stp;
    logic       hiz;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'hF, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0},
    '{4'hF, 4'hA, 4'h5, 1'b1, 1'b0, 1'b0},
    '{4'h0, 4'h0, 4'h9, 1'b1, 1'b0, 1'b0},
    '{4'hF, 4'h0, 4'hF, 1'b0, 1'b0, 1'b0},
    '{4'h0, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0},
    '{4'hF, 4'h0, 4'h0, 1'b1, 1'b1, 1'b1},
    '{4'hF, 4'h3, 4'h0, 1'b1, 1'b1, 1'b0},
    '{4'h5, 4'h0, 4'hA, 1'b1, 1'b0, 1'b0}
  };

  // Reference model written from the requirements; bits 2 and 3 are shared.
  function automatic logic [3:0] exp_pull(logic [3:0] d, logic [3:0] q,
                                          logic s, logic released);
    logic [3:0] bias = s ? 4'b0000 : 4'b1100;
    if (released) return 4'b0000;
    return d & ~q & ~bias;
  endfunction

  function automatic logic [3:0] exp_read(logic [3:0] d, logic [3:0] q,
                                          logic [3:0] p, logic s);
    logic [3:0] bias = s ? 4'b0000 : 4'b1100;
    return ((d & q) | (~d & p)) & ~bias;
  endfunction

  task automatic check(string req, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic write_reg(logic to_dir, logic [3:0] v);
    wr_en = 1'b1; wr_dir = to_dir; wr_data = v;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    pad_in = 4'h6;
    tick(2);
    rst_n = 1'b1;
    tick(3);
    // R1 reset state: no pulls, inputs read pad (bias bits read 0, R5)
    check("R1 pd_en after reset", pd_en, 4'h0);
    rd_en = 1'b1; #1;
    check("R1 read after reset", rd_data, 4'h2);
    write_reg(1'b1, 4'hF); rd_en = 1'b1; #1;
    lcd_port_sel = 1'b1; #1;
    check("R1 data reset ones (R6 R10 read latch)", rd_data, 4'hF);
    write_reg(1'b1, 4'h0);

    // Vector table: R2 R3 R4 R5 R6 R7 R8
    for (int k = 0; k < 8; k++) begin
      stop_req = 1'b0; rd_en = 1'b0;
      write_reg(1'b1, VECS[k].dir);
      write_reg(1'b0, VECS[k].dat);
      pad_in = VECS[k].pad; lcd_port_sel = VECS[k].sel; stby_hiz = VECS[k].hiz;
      tick(3);
      stop_req = VECS[k].stp;
      tick(1);
      rd_en = 1'b1; #1;
      check($sformatf("R2 R5 R7 pd_en vec %0d", k), pd_en,
            exp_pull(VECS[k].dir, VECS[k].dat, VECS[k].sel, VECS[k].stp & VECS[k].hiz));
      check($sformatf("R3 R4 R5 R6 read vec %0d", k), rd_data,
            exp_read(VECS[k].dir, VECS[k].dat, VECS[k].pad, VECS[k].sel));
    end
    stop_req = 1'b0; rd_en = 1'b0;
    tick(1);

    // R9: idle read bus
    write_reg(1'b1, 4'hF); write_reg(1'b0, 4'hF); lcd_port_sel = 1'b1; #1;
    check("R9 idle read zero", rd_data, 4'h0);

    // R4 synchronizer latency
    write_reg(1'b1, 4'h0); pad_in = 4'h0; tick(3);
    pad_in = 4'hB; rd_en = 1'b1;
    tick(1); #1;
    check("R4 pad not visible after one edge", rd_data, 4'h0);
    tick(1); #1;
    check("R4 pad visible after two edges", rd_data, 4'hB);
    rd_en = 1'b0;

    // R8: standby bit captured at entry, later change ignored
    write_reg(1'b1, 4'hF); write_reg(1'b0, 4'h0);
    stby_hiz = 1'b0; stop_req = 1'b1; tick(1);
    stby_hiz = 1'b1; tick(2);
    check("R8 hiz change inside stop ignored", pd_en, 4'hF);
    stop_req = 1'b0; tick(1);
    // R7: entry with bit set, then clearing it inside stop changes nothing
    stop_req = 1'b1; tick(1);
    stby_hiz = 1'b0; tick(2);
    check("R7 released through stop", pd_en, 4'h0);
    stop_req = 1'b0; tick(1);
    check("R7 drive restored after stop", pd_en, 4'hF);

    // R5: bias override despite data 0 and direction 1
    lcd_port_sel = 1'b0; #1;
    check("R5 bias pins released", pd_en, 4'h3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule